// File: doc/BRIEF.md
# Stereo Audio Serial Port (Slave)

This block is the serial side of a stereo audio converter that is clocked from outside. Every register runs on the incoming bit clock `sclk`. The frame strobe `lrck` splits each frame into two half-frames: a high level selects the left channel and a low level selects the right channel. Each half-frame starts its own slot count at 0. Samples are 20-bit two's complement and travel MSB first in both directions, but the two directions place the sample differently inside the half-frame.

- **Transmit:** the sample on `sdto` starts in slot 0.
- **Receive:** in wide mode the sample on `sdti` ends in the last slot of the half-frame.

A mode pin selects the half-frame length:

- **Wide mode:** 32 slots per half-frame (bit clock at 64 times the frame rate).
- **Narrow mode:** 16 slots per half-frame (bit clock at 32 times the frame rate). Only the upper 16 sample bits are carried.

Software places transmit samples in two holding registers, one per channel, through write strobes. Each received sample appears on a shared data bus with a one-cycle strobe that names its channel.

A small framing state machine follows the channel.

- **States:** `ST_SYNC` (the first cycle after reset, used to capture `lrck`), `ST_WAIT` (no frame edge seen yet), `ST_LEFT` and `ST_RIGHT`.
- **T_BOOT:** `ST_SYNC` moves to `ST_WAIT` unconditionally.
- **T_LOCK_L and T_LOCK_R:** `ST_WAIT` moves to `ST_LEFT` on a rising `lrck` and to `ST_RIGHT` on a falling `lrck`.
- **T_TO_R:** `ST_LEFT` moves to `ST_RIGHT` on a falling `lrck`.
- **T_TO_L:** `ST_RIGHT` moves to `ST_LEFT` on a rising `lrck`.

Every `lrck` change restarts the slot counter at slot 0. The counter saturates when no edge arrives.

Top module: `stereo_serial_port`

## Requirements
- R1: While reset is asserted, and after reset until the first `lrck` edge, `sdto`, `rx_data`, `rx_left_vld` and `rx_right_vld` are all 0.
- R2: In wide mode (`wide_mode`=1), `sdto` carries bit 19−k of the transmitted sample in slot k, for k = 0 to 19. `sdto` changes on falling `sclk` edges and is valid at each rising edge.
- R3: In wide mode, `sdto` is 0 in slots 20 to 31.
- R4: In wide mode, `sdti` is sampled on rising `sclk`. Slot k (k = 12 to 31) supplies bit 31−k of the received sample. Slots 0 to 11 have no effect on the result.
- R5: After the last data slot of a half-frame (slot 31 in wide mode, 15 in narrow mode), the received sample appears on `rx_data` for one cycle. In that cycle exactly one strobe is high: `rx_left_vld` for a half-frame with `lrck` high, `rx_right_vld` for a half-frame with `lrck` low.
- R6: In narrow mode (`wide_mode`=0), `sdto` carries bit 19−k of the sample in slot k, for k = 0 to 15.
- R7: In narrow mode, slot k (k = 0 to 15) supplies bit 19−k of the received sample, and bits 3 to 0 are 0.
- R8: An `lrck` change before the last data slot restarts the slot count at 0. The cut-short half-frame gives no strobe, and the next full half-frame is received and sent correctly.
- R9: A one-cycle write strobe loads the holding register of its channel (`tx_left_we` for left, `tx_right_we` for right). The value is sent from the next half-frame of that channel that starts after the write. A half-frame already in progress keeps sending the value it started with.
- R10: While `lrck` does not change, no strobe is produced, including a held `lrck` after a complete half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Bit clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: 32 slots per half-frame; 0: 16 slots |
| lrck | input | 1 | Frame strobe; high = left half-frame |
| sdti | input | 1 | Serial receive data, sampled on rising `sclk` |
| sdto | output | 1 | Serial transmit data, changes on falling `sclk` |
| tx_left_data | input | 20 | Left sample to send |
| tx_left_we | input | 1 | Loads `tx_left_data` into the left holding register |
| tx_right_data | input | 20 | Right sample to send |
| tx_right_we | input | 1 | Loads `tx_right_data` into the right holding register |
| rx_data | output | 20 | Last received sample |
| rx_left_vld | output | 1 | One-cycle strobe: `rx_data` is a left sample |
| rx_right_vld | output | 1 | One-cycle strobe: `rx_data` is a right sample |

## Verification
The bench builds the block with its default parameters: 20-bit samples, a wide half-frame of 32 slots and a narrow half-frame of 16 slots. It switches `wide_mode` at run time, so a single build reaches both slot layouts: wide mode with its 12 ignored leading slots and 12 zero trailing slots, and narrow mode with its zero-padded low bits. With the same parameters, long stretches of constant `lrck` drive the slot counter into saturation, and early `lrck` edges cut half-frames short.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } frame_state_t;
endpackage

// File: rtl/sport_frame_ctrl.sv
module sport_frame_ctrl
    import sport_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic               sclk,
    input  logic               rst_n,
    input  logic               lrck,
    output logic               lr_change,
    output logic [SLOT_W-1:0]  cur_slot,
    output frame_state_t       state
);
    localparam logic [SLOT_W-1:0] SLOT_SAT = '1;

    frame_state_t      state_q, state_nxt;
    logic              lrck_q;
    logic [SLOT_W-1:0] slot_q;

    // An lrck level that differs from the last sampled one marks slot 0.
    always_comb begin
        lr_change = (lrck != lrck_q) && (state_q != ST_SYNC);
        if (lr_change)
            cur_slot = '0;
        else if (slot_q == SLOT_SAT)
            cur_slot = SLOT_SAT;
        else
            cur_slot = slot_q + 1'b1;
    end

    // Next-state logic: T_BOOT, T_LOCK_L/R, T_TO_L, T_TO_R.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_SYNC:                    state_nxt = ST_WAIT;
            ST_WAIT, ST_LEFT, ST_RIGHT: if (lr_change)
                                            state_nxt = lrck ? ST_LEFT : ST_RIGHT;
            default:                    state_nxt = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_nxt;
    end

    // Slot counter and level history.
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            lrck_q <= 1'b0;
            slot_q <= SLOT_SAT;
        end else begin
            lrck_q <= lrck;
            slot_q <= (state_q == ST_SYNC) ? SLOT_SAT : cur_slot;
        end
    end

    assign state = state_q;

    p_realign_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        lr_change |=> (slot_q == '0));
    p_boot_r1: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == ST_SYNC) |=> (state_q == ST_WAIT));
    p_left_level_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == ST_LEFT) |-> lrck_q);
    p_right_level_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == ST_RIGHT) |-> !lrck_q);
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int SAMPLE_W     = 20,
    parameter int SLOTS_WIDE   = 32,
    parameter int SLOTS_NARROW = 16,
    parameter int SLOT_W       = 6
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic                sdti,
    input  logic [SLOT_W-1:0]   cur_slot,
    input  frame_state_t        state,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_left_vld,
    output logic                rx_right_vld
);
    localparam int                PAD_W       = SAMPLE_W - SLOTS_NARROW;
    localparam logic [SLOT_W-1:0] WIDE_FIRST  = SLOT_W'(SLOTS_WIDE - SAMPLE_W);
    localparam logic [SLOT_W-1:0] WIDE_LAST   = SLOT_W'(SLOTS_WIDE - 1);
    localparam logic [SLOT_W-1:0] NARROW_LAST = SLOT_W'(SLOTS_NARROW - 1);

    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] assembled;
    logic                in_win, at_last;

    always_comb begin
        if (wide_mode) begin
            in_win    = (cur_slot >= WIDE_FIRST) && (cur_slot <= WIDE_LAST);
            at_last   = (cur_slot == WIDE_LAST);
            assembled = {shreg[SAMPLE_W-2:0], sdti};
        end else begin
            in_win    = (cur_slot <= NARROW_LAST);
            at_last   = (cur_slot == NARROW_LAST);
            assembled = {shreg[SLOTS_NARROW-2:0], sdti, {PAD_W{1'b0}}};
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            shreg        <= '0;
            rx_data      <= '0;
            rx_left_vld  <= 1'b0;
            rx_right_vld <= 1'b0;
        end else begin
            if (in_win) shreg <= {shreg[SAMPLE_W-2:0], sdti};
            rx_left_vld  <= at_last && (state == ST_LEFT);
            rx_right_vld <= at_last && (state == ST_RIGHT);
            if (at_last && (state == ST_LEFT || state == ST_RIGHT))
                rx_data <= assembled;
        end
    end

    p_strobe_pulse_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        (rx_left_vld || rx_right_vld) |=> !(rx_left_vld || rx_right_vld));
    p_strobe_excl_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        $onehot0({rx_left_vld, rx_right_vld}));
    p_narrow_pad_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        ((rx_left_vld || rx_right_vld) && !wide_mode && $stable(wide_mode))
        |-> (rx_data[PAD_W-1:0] == '0));
endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int SAMPLE_W = 20
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                lrck,
    input  logic                lr_change,
    input  logic [SAMPLE_W-1:0] tx_left_data,
    input  logic                tx_left_we,
    input  logic [SAMPLE_W-1:0] tx_right_data,
    input  logic                tx_right_we,
    output logic                sdto
);
    // Index 1 holds the left channel, index 0 the right channel.
    logic [1:0][SAMPLE_W-1:0] hold;
    logic [1:0][SAMPLE_W-1:0] wr_data;
    logic [1:0]               wr_en;
    logic [SAMPLE_W-1:0]      next_sample;
    logic [SAMPLE_W-1:0]      tx_sr;
    logic                     msb_q, p_tog, n_tog, sdto_q;

    always_comb begin
        wr_data     = {tx_left_data, tx_right_data};
        wr_en       = {tx_left_we, tx_right_we};
        next_sample = lrck ? hold[1] : hold[0];
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else begin
            for (int c = 0; c < 2; c++)
                if (wr_en[c]) hold[c] <= wr_data[c];
        end
    end

    // Rising edge: load at slot 0 (MSB already on the line), shift otherwise.
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            msb_q <= 1'b0;
            p_tog <= 1'b0;
        end else if (lr_change) begin
            tx_sr <= {next_sample[SAMPLE_W-2:0], 1'b0};
            msb_q <= next_sample[SAMPLE_W-1];
            p_tog <= ~p_tog;
        end else begin
            tx_sr <= {tx_sr[SAMPLE_W-2:0], 1'b0};
        end
    end

    // Falling edge: present the bit for the coming slot.
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            sdto_q <= 1'b0;
            n_tog  <= 1'b0;
        end else begin
            sdto_q <= tx_sr[SAMPLE_W-1];
            n_tog  <= p_tog;
        end
    end

    // Slot 0: the MSB is shown from the lrck change until the next falling edge.
    always_comb begin
        if (lr_change)           sdto = next_sample[SAMPLE_W-1];
        else if (p_tog != n_tog) sdto = msb_q;
        else                     sdto = sdto_q;
    end
endmodule

// File: rtl/stereo_serial_port.sv
module stereo_serial_port
    import sport_pkg::*;
#(
    parameter int SAMPLE_W     = 20,
    parameter int SLOTS_WIDE   = 32,
    parameter int SLOTS_NARROW = 16
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic                lrck,
    input  logic                sdti,
    output logic                sdto,
    input  logic [SAMPLE_W-1:0] tx_left_data,
    input  logic                tx_left_we,
    input  logic [SAMPLE_W-1:0] tx_right_data,
    input  logic                tx_right_we,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_left_vld,
    output logic                rx_right_vld
);
    localparam int                SLOT_W     = $clog2(SLOTS_WIDE) + 1;
    localparam logic [SLOT_W-1:0] TAIL_FIRST = SLOT_W'(SAMPLE_W);
    localparam logic [SLOT_W-1:0] TAIL_LAST  = SLOT_W'(SLOTS_WIDE - 1);

    logic              lr_change;
    logic [SLOT_W-1:0] cur_slot;
    frame_state_t      state;

    sport_frame_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .lrck      (lrck),
        .lr_change (lr_change),
        .cur_slot  (cur_slot),
        .state     (state)
    );

    sport_rx #(
        .SAMPLE_W     (SAMPLE_W),
        .SLOTS_WIDE   (SLOTS_WIDE),
        .SLOTS_NARROW (SLOTS_NARROW),
        .SLOT_W       (SLOT_W)
    ) u_rx (
        .sclk         (sclk),
        .rst_n        (rst_n),
        .wide_mode    (wide_mode),
        .sdti         (sdti),
        .cur_slot     (cur_slot),
        .state        (state),
        .rx_data      (rx_data),
        .rx_left_vld  (rx_left_vld),
        .rx_right_vld (rx_right_vld)
    );

    sport_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .sclk          (sclk),
        .rst_n         (rst_n),
        .lrck          (lrck),
        .lr_change     (lr_change),
        .tx_left_data  (tx_left_data),
        .tx_left_we    (tx_left_we),
        .tx_right_data (tx_right_data),
        .tx_right_we   (tx_right_we),
        .sdto          (sdto)
    );

    p_tail_zero_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        (wide_mode && state != ST_SYNC && !lr_change &&
         cur_slot >= TAIL_FIRST && cur_slot <= TAIL_LAST) |-> !sdto);
endmodule

// File: tb/tb_stereo_serial_port.sv
module tb_stereo_serial_port;
    localparam int W = 20;

    logic         sclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wide_mode = 1'b1;
    logic         lrck = 1'b0;
    logic         sdti = 1'b0;
    logic         sdto;
    logic [W-1:0] tx_left_data = '0, tx_right_data = '0;
    logic         tx_left_we = 1'b0, tx_right_we = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_left_vld, rx_right_vld;

    typedef struct {
        bit           left;
        logic [W-1:0] data;
        string        tag;
    } rx_item_t;

    rx_item_t     exp_q[$];
    int           checks = 0, errors = 0;
    bit           finished = 0;
    logic [W-1:0] mdl_l = '0, mdl_r = '0;

    always #10 sclk = ~sclk;   // 50 MHz

    stereo_serial_port dut (
        .sclk(sclk), .rst_n(rst_n), .wide_mode(wide_mode), .lrck(lrck),
        .sdti(sdti), .sdto(sdto),
        .tx_left_data(tx_left_data), .tx_left_we(tx_left_we),
        .tx_right_data(tx_right_data), .tx_right_we(tx_right_we),
        .rx_data(rx_data), .rx_left_vld(rx_left_vld), .rx_right_vld(rx_right_vld)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge sclk); #2;
            sdti = 1'b0;
        end
    endtask

    task automatic set_hold(bit left, logic [W-1:0] v);
        @(negedge sclk); #2;
        if (left) begin tx_left_data = v;  tx_left_we = 1'b1; mdl_l = v; end
        else      begin tx_right_data = v; tx_right_we = 1'b1; mdl_r = v; end
        @(posedge sclk); #1;
        tx_left_we = 1'b0; tx_right_we = 1'b0;
    endtask

    // One half-frame: drives lrck/sdti per slot, checks sdto before each
    // rising edge, and queues the expected received sample when complete.
    task automatic half(bit left, logic [W-1:0] rxs, int nslots,
                        int wr_slot, logic [W-1:0] wr_val);
        logic [W-1:0] txs;
        int           full;
        logic         exp_bit;
        txs  = left ? mdl_l : mdl_r;
        full = wide_mode ? 32 : 16;
        for (int k = 0; k < nslots; k++) begin
            @(negedge sclk); #2;
            lrck = left;
            if (wide_mode) sdti = (k >= 12) ? rxs[31-k] : 1'($urandom_range(0, 1));
            else           sdti = rxs[W-1-k];
            if (k == wr_slot) begin
                if (left) begin tx_left_data = wr_val;  tx_left_we = 1'b1; mdl_l = wr_val; end
                else      begin tx_right_data = wr_val; tx_right_we = 1'b1; mdl_r = wr_val; end
            end
            #6;
            exp_bit = (k < 20) ? txs[W-1-k] : 1'b0;
            if (!wide_mode)     chk("R6", 32'(sdto), 32'(exp_bit), $sformatf("narrow slot %0d", k));
            else if (k < 20)    chk("R2", 32'(sdto), 32'(exp_bit), $sformatf("wide slot %0d", k));
            else                chk("R3", 32'(sdto), 32'(exp_bit), $sformatf("tail slot %0d", k));
            if (k == wr_slot) begin
                @(posedge sclk); #1;
                tx_left_we = 1'b0; tx_right_we = 1'b0;
            end
        end
        if (nslots == full) begin
            rx_item_t it;
            it.left = left;
            it.data = wide_mode ? rxs : {rxs[W-1:4], 4'b0};
            it.tag  = wide_mode ? "R4" : "R7";
            exp_q.push_back(it);
        end
    endtask

    // Scoreboard monitor: every strobe must match the next expected item.
    initial begin
        forever begin
            @(negedge sclk); #1;
            if (rst_n && (rx_left_vld || rx_right_vld)) begin
                chk("R5", 32'(rx_left_vld && rx_right_vld), 32'd0, "both strobes");
                if (exp_q.size() == 0) begin
                    chk("R10", 32'd1, 32'd0, "unexpected strobe (R8)");
                end else begin
                    rx_item_t it;
                    it = exp_q.pop_front();
                    chk("R5", 32'(rx_left_vld), 32'(it.left), "channel strobe");
                    chk(it.tag, 32'(rx_data), 32'(it.data), "received sample");
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge sclk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge sclk);
        #1;
        chk("R1", 32'(sdto), 32'd0, "sdto in reset");
        chk("R1", 32'(rx_left_vld | rx_right_vld), 32'd0, "strobes in reset");
        chk("R1", 32'(rx_data), 32'd0, "rx_data in reset");
        #1 rst_n = 1'b1;

        // Before any lrck edge: quiet outputs, holding registers loaded.
        set_hold(1'b1, 20'hA5C3E);
        set_hold(1'b0, 20'h5A0F1);
        idle(40);
        chk("R1", 32'(sdto), 32'd0, "sdto before first edge");

        // Wide mode, several patterns including two's complement extremes.
        half(1'b1, 20'h81234, 32, -1, '0);
        half(1'b0, 20'h3C96A, 32, -1, '0);
        set_hold(1'b1, 20'h7FFFF);   // extends right half past slot 31 (R10)
        set_hold(1'b0, 20'h80000);
        half(1'b1, 20'h7FFFF, 32, -1, '0);
        half(1'b0, 20'h80000, 32, -1, '0);

        // R9: write during a left half-frame; takes effect next left half.
        half(1'b1, 20'h00001, 32, 5, 20'h0F0F0);
        half(1'b0, 20'hFFFFE, 32, -1, '0);
        half(1'b1, 20'h55555, 32, -1, '0);

        // R8: early lrck edge cuts a right half short; recovery follows.
        half(1'b0, 20'hDEADB, 10, -1, '0);
        half(1'b1, 20'h12345, 32, -1, '0);
        half(1'b0, 20'hABCDE, 32, -1, '0);

        // R10: lrck held for a long time after a full half-frame.
        idle(80);

        // Narrow mode.
        wide_mode = 1'b0;
        idle(4);
        half(1'b1, 20'hFEDCB, 16, -1, '0);
        half(1'b0, 20'h13579, 16, -1, '0);
        half(1'b1, 20'h0000F, 8, -1, '0);   // R8 in narrow mode
        half(1'b0, 20'h8421F, 16, -1, '0);
        half(1'b1, 20'h7A5A5, 16, 3, 20'h33333);
        half(1'b0, 20'h2468A, 16, -1, '0);
        half(1'b1, 20'h6C6C6, 16, -1, '0);

        idle(10);
        chk("R5", 32'(exp_q.size()), 32'd0, "missing strobes");
        finish_run();
    end
endmodule